// File: doc/BRIEF.md
# Triggered Sample Capture Controller

This block runs the acquisition side of a 24-channel logic analyser that stores into an external asynchronous static RAM. The host sets a trigger made of a per-channel care bit and value bit, a sample pacing source, the number of live channels and the number of samples, then arms the block. While armed, the block compares the registered probe inputs with the trigger on every system clock. The first sample that matches is written to RAM address 0. Further samples are written at consecutive addresses, one per pacing tick, until the chosen depth is full. The block then reports that the capture is complete.

Samples can be paced in two ways. The internal way is a divider of the system clock, with a period from one clock (30 ns at 33.33 MHz) to more than 8333 clocks (250 us). The external way takes an outside clock through a two-flop synchronizer and detects its rising edges. The block keeps every (N+1)th edge and delays each kept edge by a set number of system clocks.

After capture, the host asks for a window of samples by giving a start address and a word count. The block reads the RAM at auto-incrementing addresses and returns the words on a valid/ready stream. The RAM must return `ram_rdata` in the same cycle that `ram_addr` is presented. When the consumer holds `rb_ready` low, the block holds the address and therefore the data, so no word is lost or skipped. A transfer takes place on every cycle where `rb_valid` and `rb_ready` are both high.

Top module: `la_capture_ctrl`

## Requirements
- R1: After reset, `ram_we`, `rb_valid`, `armed_o`, `capturing_o` and `done_o` are all low.
- R2: While armed, the block writes nothing until a registered probe sample has every channel with `trig_care`=1 equal to its `trig_value` bit. That matching sample is then written to address 0.
- R3: After the trigger sample, writes go to addresses 1, 2, 3 and so on, one per tick. A total of 4096 << `depth_sel` samples are written (0=4K, 1=8K, 2=16K, 3=32K). `done_o` then rises and stays high until the next arm.
- R4: With `use_ext`=0, consecutive tick writes are exactly `rate_div`+1 system clocks apart.
- R5: `chan_sel` sets the live channels: 0 gives bits 7:0, 1 gives bits 15:0, and 2 or 3 gives all 24. Bits of dead channels are zero in both written and read-back data.
- R6: With `use_ext`=1, ticks come from every (`ext_div`+1)th synchronized rising edge of `ext_clk`. Each tick is delayed by `ext_dly` system clocks, with zero meaning no delay.
- R7: A `rd_req` with a non-zero `rd_len` while done starts readback. The stream returns `rd_len` words, the first from `rd_base`, each address one higher than the last and wrapping at 32K. A stalled word holds its value. After the last transfer, `rb_valid` falls and the block is done again.
- R8: `rd_req` is ignored unless the capture is done. `arm` is ignored during capture and readback.
- R9: The trigger, pacing, channel and depth settings are latched at arm. Later changes on those inputs do not affect the capture in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm | input | 1 | Arm pulse, accepted when idle or done |
| trig_care | input | 24 | Per-channel compare enable |
| trig_value | input | 24 | Per-channel trigger level |
| rate_div | input | 14 | Internal sample period minus one, in clocks |
| use_ext | input | 1 | Select external pacing |
| ext_div | input | 4 | Keep every (ext_div+1)th external rising edge |
| ext_dly | input | 4 | Delay, in clocks, applied to each kept edge |
| chan_sel | input | 2 | Live channel count select |
| depth_sel | input | 2 | Sample depth select |
| ext_clk | input | 1 | Asynchronous external sample clock |
| probe | input | 24 | Probe inputs |
| ram_addr | output | 15 | RAM address |
| ram_wdata | output | 24 | RAM write data |
| ram_we | output | 1 | RAM write strobe |
| ram_rdata | input | 24 | RAM read data, valid in the same cycle as the address |
| rd_req | input | 1 | Readback request pulse |
| rd_base | input | 15 | Readback start address |
| rd_len | input | 16 | Readback word count |
| rb_valid | output | 1 | Readback word valid |
| rb_ready | input | 1 | Readback consumer ready |
| rb_data | output | 24 | Readback word |
| armed_o | output | 1 | Waiting for the trigger |
| capturing_o | output | 1 | Writing samples |
| done_o | output | 1 | Capture complete, stays high through readback |

## Verification
The hardest thing to bring about from the ports is the phase relation between an asynchronous external edge and the RAM write it causes. The synchronizer, the edge divider and the delay counter each add latency that the pins do not show. The stimulus drives `ext_clk` as a slow square wave locked to the bench cycle count, so every rising edge falls in a known cycle. Two external captures are run, one with no delay and one with a delay of two clocks and a divide-by-two. The bench then compares the offset from the latest rising edge to each write in the two runs, and checks the write spacing in each run.

// File: rtl/la_cap_pkg.sv
`timescale 1ns/1ps
package la_cap_pkg;
  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_ARMED    = 3'd1,
    ST_CAPTURE  = 3'd2,
    ST_DONE     = 3'd3,
    ST_READBACK = 3'd4
  } cap_state_e;
endpackage

// File: rtl/la_trig_match.sv
`timescale 1ns/1ps
module la_trig_match #(
  parameter int CH_W = 24
) (
  input  logic [CH_W-1:0] sample,
  input  logic [CH_W-1:0] care,
  input  logic [CH_W-1:0] value,
  output logic            hit
);
  logic [CH_W-1:0] ch_ok;

  for (genvar c = 0; c < CH_W; c++) begin : g_ch
    assign ch_ok[c] = ~care[c] | (sample[c] == value[c]);
  end

  assign hit = &ch_ok;
endmodule

// File: rtl/la_sample_tick.sv
`timescale 1ns/1ps
module la_sample_tick #(
  parameter int DIV_W = 14,
  parameter int EXT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             use_ext,
  input  logic [DIV_W-1:0] rate_div,
  input  logic [EXT_W-1:0] ext_div,
  input  logic [EXT_W-1:0] ext_dly,
  input  logic             ext_clk,
  output logic             tick
);
  // internal divider
  logic [DIV_W-1:0] icnt;
  logic             int_tick;
  assign int_tick = (icnt == rate_div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 icnt <= '0;
    else if (clear || int_tick) icnt <= '0;
    else                        icnt <= icnt + 1'b1;
  end

  // external clock: two-flop synchronizer plus one history flop
  logic [2:0] sync_q;
  logic       rise;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], ext_clk};
  end
  assign rise = sync_q[1] & ~sync_q[2];

  // keep every (ext_div+1)th edge
  logic [EXT_W-1:0] ecnt;
  logic             kept;
  assign kept = rise && (ecnt == ext_div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ecnt <= '0;
    else if (clear) ecnt <= '0;
    else if (rise)  ecnt <= kept ? '0 : ecnt + 1'b1;
  end

  // delay each kept edge
  logic [EXT_W-1:0] dcnt;
  logic             ext_tick;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          dcnt <= '0;
    else if (clear)                      dcnt <= '0;
    else if (kept && (ext_dly != '0))    dcnt <= ext_dly;
    else if (dcnt != '0)                 dcnt <= dcnt - 1'b1;
  end
  assign ext_tick = (kept && (ext_dly == '0)) || (dcnt == EXT_W'(1));

  assign tick = use_ext ? ext_tick : int_tick;
endmodule

// File: rtl/la_readback.sv
`timescale 1ns/1ps
module la_readback #(
  parameter int ADDR_W = 15,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base,
  input  logic [LEN_W-1:0]  len,
  input  logic              en,
  input  logic              ready,
  output logic              valid,
  output logic [ADDR_W-1:0] ptr,
  output logic              finish
);
  logic [LEN_W-1:0] left;
  logic             xfer;

  assign valid  = en;
  assign xfer   = en && ready;
  assign finish = xfer && (left == LEN_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr  <= '0;
      left <= '0;
    end else if (start) begin
      ptr  <= base;
      left <= len;
    end else if (xfer) begin
      ptr  <= ptr + 1'b1;
      left <= left - 1'b1;
    end
  end
endmodule

// File: rtl/la_capture_ctrl.sv
`timescale 1ns/1ps
module la_capture_ctrl
  import la_cap_pkg::*;
#(
  parameter int CH_W   = 24,
  parameter int ADDR_W = 15,
  parameter int DIV_W  = 14,
  parameter int EXT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic [CH_W-1:0]   trig_care,
  input  logic [CH_W-1:0]   trig_value,
  input  logic [DIV_W-1:0]  rate_div,
  input  logic              use_ext,
  input  logic [EXT_W-1:0]  ext_div,
  input  logic [EXT_W-1:0]  ext_dly,
  input  logic [1:0]        chan_sel,
  input  logic [1:0]        depth_sel,
  input  logic              ext_clk,
  input  logic [CH_W-1:0]   probe,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [CH_W-1:0]   ram_wdata,
  output logic              ram_we,
  input  logic [CH_W-1:0]   ram_rdata,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_base,
  input  logic [ADDR_W:0]   rd_len,
  output logic              rb_valid,
  input  logic              rb_ready,
  output logic [CH_W-1:0]   rb_data,
  output logic              armed_o,
  output logic              capturing_o,
  output logic              done_o
);
  localparam int GRP   = CH_W / 3;
  localparam int LEN_W = ADDR_W + 1;
  localparam int MIN_W = ADDR_W - 3;  // log2 of the smallest depth

  cap_state_e state;

  // settings latched at arm
  logic [CH_W-1:0]  care_q, value_q;
  logic [DIV_W-1:0] rate_q;
  logic             ext_q;
  logic [EXT_W-1:0] ediv_q, edly_q;
  logic [1:0]       chan_q, depth_q;

  logic [CH_W-1:0]   probe_q;
  logic [CH_W-1:0]   chmask;
  logic [ADDR_W-1:0] last_addr;
  logic [ADDR_W-1:0] wcnt, addr_q;
  logic [CH_W-1:0]   wdata_q;
  logic              we_q;
  logic              hit, tick, rb_finish, rb_start, arm_ok;
  logic [ADDR_W-1:0] rd_ptr;

  for (genvar g = 0; g < 3; g++) begin : g_chmask
    assign chmask[g*GRP +: GRP] = {GRP{chan_q >= 2'(g)}};
  end

  for (genvar i = 0; i < ADDR_W; i++) begin : g_last
    if (i < MIN_W) begin : g_low
      assign last_addr[i] = 1'b1;
    end else begin : g_high
      assign last_addr[i] = (depth_q > 2'(i - MIN_W));
    end
  end

  la_trig_match #(.CH_W(CH_W)) u_match (
    .sample (probe_q),
    .care   (care_q),
    .value  (value_q),
    .hit    (hit)
  );

  la_sample_tick #(.DIV_W(DIV_W), .EXT_W(EXT_W)) u_tick (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (state == ST_ARMED),
    .use_ext  (ext_q),
    .rate_div (rate_q),
    .ext_div  (ediv_q),
    .ext_dly  (edly_q),
    .ext_clk  (ext_clk),
    .tick     (tick)
  );

  assign rb_start = (state == ST_DONE) && !arm && rd_req && (rd_len != '0);

  la_readback #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_rb (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (rb_start),
    .base   (rd_base),
    .len    (rd_len),
    .en     (state == ST_READBACK),
    .ready  (rb_ready),
    .valid  (rb_valid),
    .ptr    (rd_ptr),
    .finish (rb_finish)
  );

  assign arm_ok = arm && ((state == ST_IDLE) || (state == ST_DONE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) probe_q <= '0;
    else        probe_q <= probe;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      care_q  <= '0;
      value_q <= '0;
      rate_q  <= '0;
      ext_q   <= 1'b0;
      ediv_q  <= '0;
      edly_q  <= '0;
      chan_q  <= '0;
      depth_q <= '0;
    end else if (arm_ok) begin
      care_q  <= trig_care;
      value_q <= trig_value;
      rate_q  <= rate_div;
      ext_q   <= use_ext;
      ediv_q  <= ext_div;
      edly_q  <= ext_dly;
      chan_q  <= chan_sel;
      depth_q <= depth_sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      wcnt    <= '0;
    end else begin
      we_q <= 1'b0;
      unique case (state)
        ST_IDLE: if (arm_ok) state <= ST_ARMED;
        ST_ARMED: begin
          if (hit) begin
            state   <= ST_CAPTURE;
            we_q    <= 1'b1;
            addr_q  <= '0;
            wdata_q <= probe_q & chmask;
            wcnt    <= ADDR_W'(1);
          end
        end
        ST_CAPTURE: begin
          if (tick) begin
            we_q    <= 1'b1;
            addr_q  <= wcnt;
            wdata_q <= probe_q & chmask;
            wcnt    <= wcnt + 1'b1;
            if (wcnt == last_addr) state <= ST_DONE;
          end
        end
        ST_DONE: begin
          if (arm_ok)        state <= ST_ARMED;
          else if (rb_start) state <= ST_READBACK;
        end
        ST_READBACK: if (rb_finish) state <= ST_DONE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign ram_we      = we_q;
  assign ram_wdata   = wdata_q;
  assign ram_addr    = (state == ST_READBACK) ? rd_ptr : addr_q;
  assign rb_data     = ram_rdata & chmask;
  assign armed_o     = (state == ST_ARMED);
  assign capturing_o = (state == ST_CAPTURE);
  assign done_o      = (state == ST_DONE) || (state == ST_READBACK);
endmodule

// File: rtl/la_capture_ctrl_chk.sv
`timescale 1ns/1ps
module la_capture_ctrl_chk
  import la_cap_pkg::*;
#(
  parameter int CH_W   = 24,
  parameter int ADDR_W = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        state,
  input logic              ram_we,
  input logic [ADDR_W-1:0] ram_addr,
  input logic [CH_W-1:0]   ram_wdata,
  input logic [CH_W-1:0]   chmask,
  input logic              rb_valid,
  input logic              rb_ready
);
  logic [ADDR_W-1:0] prev_wr;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      prev_wr <= '0;
    else if (ram_we) prev_wr <= ram_addr;
  end

  p_we_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> ($past(state) == ST_ARMED || $past(state) == ST_CAPTURE));

  p_first_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && $past(state) == ST_ARMED) |-> (ram_addr == '0));

  p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && $past(state) == ST_CAPTURE) |-> (ram_addr == prev_wr + 1'b1));

  p_chan_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> ((ram_wdata & ~chmask) == '0));

  p_rb_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rb_valid && !rb_ready) |=> (rb_valid && $stable(ram_addr)));

  p_rb_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_READBACK) |-> !ram_we);
endmodule

bind la_capture_ctrl la_capture_ctrl_chk #(.CH_W(CH_W), .ADDR_W(ADDR_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .state     (state),
  .ram_we    (ram_we),
  .ram_addr  (ram_addr),
  .ram_wdata (ram_wdata),
  .chmask    (chmask),
  .rb_valid  (rb_valid),
  .rb_ready  (rb_ready)
);

// File: tb/la_capture_ctrl_tb_top.sv
`timescale 1ns/1ps
module la_capture_ctrl_tb_top;
  localparam int CLK_PERIOD = 30;
  localparam int WATCHDOG   = 190000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        arm = 1'b0;
  logic [23:0] trig_care = '0, trig_value = '0;
  logic [13:0] rate_div = '0;
  logic        use_ext = 1'b0;
  logic [3:0]  ext_div = '0, ext_dly = '0;
  logic [1:0]  chan_sel = 2'd2, depth_sel = 2'd0;
  logic        ext_clk = 1'b0;
  logic [23:0] probe;
  logic [14:0] ram_addr;
  logic [23:0] ram_wdata, ram_rdata, rb_data;
  logic        ram_we, rb_valid, armed_o, capturing_o, done_o;
  logic        rd_req = 1'b0, rb_ready = 1'b0;
  logic [14:0] rd_base = '0;
  logic [15:0] rd_len = '0;

  logic [7:0]  hi_byte = 8'hC3;
  logic [15:0] pcnt = '0;
  assign probe = {hi_byte, pcnt};

  // asynchronous RAM model: content is a fixed function of address
  function automatic logic [23:0] ram_fn(input logic [14:0] a);
    return {~a[8:0], a};
  endfunction
  assign ram_rdata = ram_fn(ram_addr);

  always #(CLK_PERIOD/2) clk = ~clk;

  la_capture_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .arm(arm), .trig_care(trig_care), .trig_value(trig_value),
    .rate_div(rate_div), .use_ext(use_ext), .ext_div(ext_div), .ext_dly(ext_dly),
    .chan_sel(chan_sel), .depth_sel(depth_sel), .ext_clk(ext_clk), .probe(probe),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_we(ram_we), .ram_rdata(ram_rdata),
    .rd_req(rd_req), .rd_base(rd_base), .rd_len(rd_len), .rb_valid(rb_valid),
    .rb_ready(rb_ready), .rb_data(rb_data), .armed_o(armed_o),
    .capturing_o(capturing_o), .done_o(done_o)
  );

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  always @(posedge clk) cyc++;

  // probe and external clock stimulus
  logic ext_run = 1'b0;
  int   ext_ph = 0, rise_cyc = 0;
  always @(negedge clk) begin
    pcnt <= pcnt + 16'd1;
    if (ext_run) begin
      ext_ph = (ext_ph + 1) % 8;
      if (ext_ph == 0) rise_cyc = cyc;
      ext_clk <= (ext_ph < 4);
    end
  end

  // write monitor
  int          wr_n, seq_err, mask_err, gap_err, last_cyc, last_off, exp_gap;
  logic [23:0] first_data, exp_mask;
  always @(negedge clk) begin
    if (rst_n && ram_we) begin
      if (wr_n == 0) first_data = ram_wdata;
      if (ram_addr != 15'(wr_n)) seq_err++;
      if ((ram_wdata & ~exp_mask) != '0) mask_err++;
      if (wr_n >= 2 && (cyc - last_cyc) != exp_gap) gap_err++;
      last_cyc = cyc;
      last_off = cyc - rise_cyc;
      wr_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic mon_reset(input int gap, input logic [23:0] m);
    wr_n = 0; seq_err = 0; mask_err = 0; gap_err = 0; exp_gap = gap; exp_mask = m;
  endtask

  task automatic do_arm();
    @(negedge clk) arm = 1'b1;
    @(negedge clk) arm = 1'b0;
  endtask

  task automatic wait_done();
    while (!done_o) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk(!ram_we && !rb_valid, "R1 we/valid", {ram_we, rb_valid}, 0);
    chk(!armed_o && !capturing_o && !done_o, "R1 flags", {armed_o, capturing_o, done_o}, 0);
  endtask

  task automatic t_rd_idle();
    @(negedge clk) begin rd_req = 1'b1; rd_base = 15'd5; rd_len = 16'd3; end
    @(negedge clk) rd_req = 1'b0;
    repeat (3) @(negedge clk);
    chk(!rb_valid && !done_o, "R8 rd_req ignored in idle", rb_valid, 0);
  endtask

  task automatic t_trigger();
    trig_care = 24'hFF0000; trig_value = 24'hA50000; chan_sel = 2'd2;
    depth_sel = 2'd0; rate_div = '0; use_ext = 1'b0;
    mon_reset(1, 24'hFFFFFF);
    do_arm();
    repeat (40) @(negedge clk);
    chk(wr_n == 0, "R2 no write before match", wr_n, 0);
    chk(armed_o, "R2 still armed", armed_o, 1);
    hi_byte = 8'hA5;
    @(negedge clk) hi_byte = 8'hC3;
    wait_done();
    chk(first_data[23:16] == 8'hA5, "R2 trigger sample at addr 0", first_data[23:16], 8'hA5);
    chk(wr_n == 4096, "R3 4K depth count", wr_n, 4096);
    chk(seq_err == 0, "R3 sequential addresses", seq_err, 0);
    chk(gap_err == 0, "R4 period 1 clock", gap_err, 0);
  endtask

  task automatic t_rate_chan16();
    trig_care = '0; chan_sel = 2'd1; rate_div = 14'd3;
    mon_reset(4, 24'h00FFFF);
    do_arm();
    rate_div = 14'd0; chan_sel = 2'd0;  // late changes: R9
    repeat (100) @(negedge clk);
    do_arm();                           // R8 arm during capture ignored
    wait_done();
    chk(gap_err == 0, "R4 R9 period 4 clocks kept", gap_err, 0);
    chk(mask_err == 0, "R5 16 channel mask", mask_err, 0);
    chk(wr_n == 4096 && seq_err == 0, "R8 arm in capture ignored", wr_n, 4096);
  endtask

  task automatic t_readback(input logic [14:0] base, input int len);
    int idx = 0;
    int errs = 0;
    @(negedge clk) begin rd_req = 1'b1; rd_base = base; rd_len = 16'(len); end
    @(negedge clk) rd_req = 1'b0;
    for (int k = 0; k < 200 && idx < len; k++) begin
      rb_ready = (k % 3) != 2;
      if (rb_valid && rb_ready) begin
        if (rb_data != (ram_fn(base + 15'(idx)) & 24'h00FFFF)) errs++;
        idx++;
      end
      @(negedge clk);
    end
    rb_ready = 1'b0;
    chk(idx == len && errs == 0, "R7 readback words", errs, 0);
    chk(!rb_valid && done_o, "R7 back to done", rb_valid, 0);
  endtask

  task automatic t_depth8k_chan8();
    chan_sel = 2'd0; depth_sel = 2'd1; rate_div = '0;
    mon_reset(1, 24'h0000FF);
    do_arm();
    wait_done();
    chk(wr_n == 8192, "R3 8K depth count", wr_n, 8192);
    chk(mask_err == 0, "R5 8 channel mask", mask_err, 0);
  endtask

  task automatic t_ext(output int off, input int gap, input logic [3:0] dv, input logic [3:0] dl);
    chan_sel = 2'd2; depth_sel = 2'd0; use_ext = 1'b1; ext_div = dv; ext_dly = dl;
    mon_reset(gap, 24'hFFFFFF);
    do_arm();
    wait_done();
    chk(gap_err == 0 && wr_n == 4096, "R6 external spacing", gap_err, 0);
    off = last_off;
  endtask

  initial begin : main
    int off0, off2;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rd_idle();
    t_trigger();
    t_rate_chan16();
    t_readback(15'd100, 7);
    t_readback(15'd32766, 4);
    t_depth8k_chan8();
    ext_run = 1'b1;
    t_ext(off0, 8, 4'd0, 4'd0);
    t_ext(off2, 16, 4'd1, 4'd2);
    chk(off2 == off0 + 2, "R6 delay of 2 clocks", off2, off0 + 2);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule